// File: doc/BRIEF.md
# Bulk OUT Endpoint Transfer Controller

This block holds the per-endpoint control state for a device-side bulk endpoint that receives data from the host. Software loads a transfer length, selects the data direction and arms the endpoint. A packet layer below reports each received data packet with its byte count. For every reported packet the block returns a one-cycle handshake decision, ACK or NAK, one cycle later.

For each accepted packet the remaining length drops by the exact number of bytes that arrived. The block disarms itself when the transfer ends. A transfer ends when a packet arrives that is shorter than the maximum packet size, or when the remaining length reaches zero. Three sticky interrupt flags report these events, and software clears them by writing ones.

Protocol framing, CRC checking and the data buffer sit outside this block. The block only sees a packet event and a byte count.

Top module: `bulk_out_ep_ctrl`

## Requirements
- R1: After reset the endpoint is disarmed, direction is host-to-device (0), remaining length is 0, all three flags are 0 and no handshake is reported.
- R2: A packet that arrives while the endpoint is disarmed, or while direction is device-to-host (1), is answered with NAK. It leaves the remaining length, arm bit and flags unchanged.
- R3: An accepted packet is answered with ACK, and the remaining length decreases by its byte count (for example, 320 minus 259 bytes over five packets leaves 61).
- R4: Every accepted packet sets the packet-complete flag (`irq_pc`).
- R5: An accepted packet with fewer than MAX_PKT (64) bytes, including a zero-byte packet, sets transfer-complete (`irq_tc`) and clears the arm bit. Byte-count-zero (`irq_bcz`) stays clear while length remains.
- R6: An accepted packet that brings the remaining length to exactly 0 sets `irq_bcz` and `irq_tc` and clears the arm bit.
- R7: A packet whose byte count exceeds the remaining length or MAX_PKT is answered with NAK and changes neither the remaining length nor any flag.
- R8: An accepted full-size packet that leaves length remaining keeps the endpoint armed and does not set `irq_tc`.
- R9: `stat_clr` is write-1-to-clear, with bit 0 for `irq_pc`, bit 1 for `irq_bcz` and bit 2 for `irq_tc`. A flag set by a packet in the same cycle as its clear stays set.
- R10: `hs_valid` is high for exactly the one cycle after each cycle with `pkt_valid` high, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_wr | input | 1 | Write strobe for the arm bit |
| arm_val | input | 1 | Arm bit value to write |
| dir_wr | input | 1 | Write strobe for the direction bit |
| dir_val | input | 1 | Direction: 0 host-to-device, 1 device-to-host |
| len_wr | input | 1 | Write strobe for the transfer length |
| len_val | input | LEN_W | Transfer length in bytes |
| stat_clr | input | 3 | Write-1-to-clear: bit 2 tc, bit 1 bcz, bit 0 pc |
| pkt_valid | input | 1 | A data packet was received this cycle |
| pkt_bytes | input | CNT_W | Byte count of the received packet |
| hs_valid | output | 1 | Handshake decision valid |
| hs_ack | output | 1 | 1 = ACK, 0 = NAK |
| remain_len | output | LEN_W | Remaining transfer length |
| armed | output | 1 | Current arm bit |
| irq_tc | output | 1 | Transfer-complete flag |
| irq_bcz | output | 1 | Byte-count-zero flag |
| irq_pc | output | 1 | Packet-complete flag |

## Verification
A corrupted remaining length shows on `remain_len` in the cycle after the packet that caused it. It also changes later decisions, because a packet that should fit gets NAKed. A stale arm bit shows on the very next packet as an ACK where a NAK belongs. The sweep covers every byte count from 0 to one past MAX_PKT against lengths on either side of a packet boundary, so any error in the short-packet or zero-length decision shows within one packet.

// File: rtl/bulk_ep_pkg.sv
package bulk_ep_pkg;
  typedef enum logic {
    EP_DIR_H2D = 1'b0,
    EP_DIR_D2H = 1'b1
  } ep_dir_e;

  typedef struct packed {
    logic tc;
    logic bcz;
    logic pc;
  } ep_evt_t;

  localparam int unsigned EP_EVT_W = 3;
endpackage

// File: rtl/ep_rst_sync.sv
module ep_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign rst_sync_n = s2_q;
endmodule

// File: rtl/ep_pkt_judge.sv
module ep_pkt_judge
  import bulk_ep_pkg::*;
#(
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned MAX_PKT = 64,
  parameter int unsigned CNT_W   = $clog2(MAX_PKT + 1)
) (
  input  logic             pkt_valid,
  input  logic [CNT_W-1:0] pkt_bytes,
  input  logic             armed,
  input  ep_dir_e          dir,
  input  logic [LEN_W-1:0] remain,
  output logic             accept,
  output ep_evt_t          evt,
  output logic             disarm_req,
  output logic [LEN_W-1:0] rem_after
);
  localparam logic [CNT_W-1:0] MAX_C = CNT_W'(MAX_PKT);

  logic [LEN_W-1:0] bytes_ext;
  logic             fits_pkt;
  logic             fits_len;
  logic             is_short;
  logic             hit_zero;

  always_comb begin
    bytes_ext  = LEN_W'(pkt_bytes);
    fits_pkt   = (pkt_bytes <= MAX_C);
    fits_len   = (bytes_ext <= remain);
    accept     = pkt_valid & armed & (dir == EP_DIR_H2D) & fits_pkt & fits_len;
    rem_after  = remain - bytes_ext;
    is_short   = (pkt_bytes < MAX_C);
    hit_zero   = (rem_after == '0);
    evt.pc     = accept;
    evt.bcz    = accept & hit_zero;
    evt.tc     = accept & (is_short | hit_zero);
    disarm_req = evt.tc;
  end
endmodule

// File: rtl/ep_len_reg.sv
module ep_len_reg #(
  parameter int unsigned LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             len_wr,
  input  logic [LEN_W-1:0] len_val,
  input  logic             upd_en,
  input  logic [LEN_W-1:0] upd_val,
  output logic [LEN_W-1:0] remain
);
  logic [LEN_W-1:0] rem_q, rem_d;
  logic             rem_en;

  always_comb begin
    rem_d  = rem_q;
    rem_en = len_wr | upd_en;
    if (upd_en) rem_d = upd_val;
    if (len_wr) rem_d = len_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rem_q <= '0;
    else if (rem_en) rem_q <= rem_d;
  end

  assign remain = rem_q;
endmodule

// File: rtl/ep_arm_ctrl.sv
module ep_arm_ctrl
  import bulk_ep_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    arm_wr,
  input  logic    arm_val,
  input  logic    dir_wr,
  input  logic    dir_val,
  input  logic    disarm_req,
  output logic    armed,
  output ep_dir_e dir
);
  logic    arm_q, arm_d, arm_en;
  ep_dir_e dir_q, dir_d;

  always_comb begin
    arm_d  = arm_q;
    arm_en = arm_wr | disarm_req;
    if (disarm_req) arm_d = 1'b0;
    if (arm_wr)     arm_d = arm_val;
    dir_d = ep_dir_e'(dir_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      arm_q <= 1'b0;
    else if (arm_en) arm_q <= arm_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= EP_DIR_H2D;
    else if (dir_wr) dir_q <= dir_d;
  end

  assign armed = arm_q;
  assign dir   = dir_q;
endmodule

// File: rtl/ep_irq_status.sv
module ep_irq_status #(
  parameter int unsigned N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic q, d, en;

    always_comb begin
      en = set[i] | clr[i];
      d  = set[i] | (q & ~clr[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= 1'b0;
      else if (en) q <= d;
    end

    assign flags[i] = q;
  end
endmodule

// File: rtl/bulk_out_ep_ctrl.sv
module bulk_out_ep_ctrl
  import bulk_ep_pkg::*;
#(
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned MAX_PKT = 64,
  parameter int unsigned CNT_W   = $clog2(MAX_PKT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_wr,
  input  logic             arm_val,
  input  logic             dir_wr,
  input  logic             dir_val,
  input  logic             len_wr,
  input  logic [LEN_W-1:0] len_val,
  input  logic [2:0]       stat_clr,
  input  logic             pkt_valid,
  input  logic [CNT_W-1:0] pkt_bytes,
  output logic             hs_valid,
  output logic             hs_ack,
  output logic [LEN_W-1:0] remain_len,
  output logic             armed,
  output logic             irq_tc,
  output logic             irq_bcz,
  output logic             irq_pc
);
  logic             rst_sync_n;
  logic             accept;
  ep_evt_t          evt;
  logic             disarm_req;
  logic [LEN_W-1:0] rem_after;
  logic [LEN_W-1:0] remain;
  logic             arm_bit;
  ep_dir_e          ep_dir;
  logic [EP_EVT_W-1:0] flags;
  logic             hs_valid_q, hs_ack_q, hs_valid_d, hs_ack_d;

  ep_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  ep_pkt_judge #(
    .LEN_W   (LEN_W),
    .MAX_PKT (MAX_PKT),
    .CNT_W   (CNT_W)
  ) u_judge (
    .pkt_valid  (pkt_valid),
    .pkt_bytes  (pkt_bytes),
    .armed      (arm_bit),
    .dir        (ep_dir),
    .remain     (remain),
    .accept     (accept),
    .evt        (evt),
    .disarm_req (disarm_req),
    .rem_after  (rem_after)
  );

  ep_len_reg #(
    .LEN_W (LEN_W)
  ) u_len (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .len_wr  (len_wr),
    .len_val (len_val),
    .upd_en  (accept),
    .upd_val (rem_after),
    .remain  (remain)
  );

  ep_arm_ctrl u_arm (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .arm_wr     (arm_wr),
    .arm_val    (arm_val),
    .dir_wr     (dir_wr),
    .dir_val    (dir_val),
    .disarm_req (disarm_req),
    .armed      (arm_bit),
    .dir        (ep_dir)
  );

  ep_irq_status #(
    .N (EP_EVT_W)
  ) u_irq (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .set   (evt),
    .clr   (stat_clr),
    .flags (flags)
  );

  always_comb begin
    hs_valid_d = pkt_valid;
    hs_ack_d   = accept;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      hs_valid_q <= 1'b0;
      hs_ack_q   <= 1'b0;
    end else begin
      hs_valid_q <= hs_valid_d;
      hs_ack_q   <= hs_ack_d;
    end
  end

  assign hs_valid   = hs_valid_q;
  assign hs_ack     = hs_ack_q;
  assign remain_len = remain;
  assign armed      = arm_bit;
  assign irq_tc     = flags[2];
  assign irq_bcz    = flags[1];
  assign irq_pc     = flags[0];
endmodule

// File: rtl/bulk_out_ep_chk.sv
module bulk_out_ep_chk #(
  parameter int unsigned LEN_W   = 16,
  parameter int unsigned MAX_PKT = 64,
  parameter int unsigned CNT_W   = $clog2(MAX_PKT + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             arm_wr,
  input logic             len_wr,
  input logic             dir_in,
  input logic             pkt_valid,
  input logic [CNT_W-1:0] pkt_bytes,
  input logic             hs_valid,
  input logic             hs_ack,
  input logic [LEN_W-1:0] remain_len,
  input logic             armed,
  input logic             irq_tc,
  input logic             irq_bcz,
  input logic             irq_pc
);
  logic [LEN_W-1:0] b_ext;
  logic             fits;
  logic             ok;

  assign b_ext = LEN_W'(pkt_bytes);
  assign fits  = (int'(pkt_bytes) <= int'(MAX_PKT)) && (b_ext <= remain_len);
  assign ok    = pkt_valid && armed && !dir_in && fits && !len_wr && !arm_wr;

  a_r10_hs_follows: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> hs_valid);
  a_r10_hs_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |=> !hs_valid);
  a_r2_nak_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && (!armed || dir_in)) |=> !hs_ack);
  a_r3_len_drop: assert property (@(posedge clk) disable iff (!rst_n)
    ok |=> (hs_ack && remain_len == $past(remain_len) - $past(b_ext)));
  a_r4_pc_set: assert property (@(posedge clk) disable iff (!rst_n)
    ok |=> irq_pc);
  a_r5_short_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && int'(pkt_bytes) < int'(MAX_PKT)) |=> (!armed && irq_tc));
  a_r6_zero_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && b_ext == remain_len) |=> (!armed && irq_bcz && irq_tc));
  a_r7_oversize_nak: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !fits && !len_wr) |=> (!hs_ack && $stable(remain_len)));
  a_r8_full_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (ok && int'(pkt_bytes) == int'(MAX_PKT) && b_ext < remain_len) |=> armed);
endmodule

bind bulk_out_ep_ctrl bulk_out_ep_chk #(
  .LEN_W   (LEN_W),
  .MAX_PKT (MAX_PKT),
  .CNT_W   (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .arm_wr     (arm_wr),
  .len_wr     (len_wr),
  .dir_in     (ep_dir == bulk_ep_pkg::EP_DIR_D2H),
  .pkt_valid  (pkt_valid),
  .pkt_bytes  (pkt_bytes),
  .hs_valid   (hs_valid),
  .hs_ack     (hs_ack),
  .remain_len (remain_len),
  .armed      (armed),
  .irq_tc     (irq_tc),
  .irq_bcz    (irq_bcz),
  .irq_pc     (irq_pc)
);

// File: tb/bulk_out_ep_ctrl_test.sv
module bulk_out_ep_ctrl_test;
  localparam int LEN_W   = 16;
  localparam int MAX_PKT = 64;
  localparam int CNT_W   = $clog2(MAX_PKT + 1);

  logic             clk = 1'b0;
  logic             rst_n;
  logic             arm_wr, arm_val, dir_wr, dir_val, len_wr;
  logic [LEN_W-1:0] len_val;
  logic [2:0]       stat_clr;
  logic             pkt_valid;
  logic [CNT_W-1:0] pkt_bytes;
  logic             hs_valid, hs_ack, armed, irq_tc, irq_bcz, irq_pc;
  logic [LEN_W-1:0] remain_len;

  int n_vec = 0;
  int n_bad = 0;
  logic got_v, got_ack;

  bulk_out_ep_ctrl #(.LEN_W(LEN_W), .MAX_PKT(MAX_PKT)) uut (
    .clk(clk), .rst_n(rst_n), .arm_wr(arm_wr), .arm_val(arm_val),
    .dir_wr(dir_wr), .dir_val(dir_val), .len_wr(len_wr), .len_val(len_val),
    .stat_clr(stat_clr), .pkt_valid(pkt_valid), .pkt_bytes(pkt_bytes),
    .hs_valid(hs_valid), .hs_ack(hs_ack), .remain_len(remain_len),
    .armed(armed), .irq_tc(irq_tc), .irq_bcz(irq_bcz), .irq_pc(irq_pc)
  );

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int flg();
    return {irq_tc, irq_bcz, irq_pc};
  endfunction

  task automatic idle_all();
    arm_wr = 0; arm_val = 0; dir_wr = 0; dir_val = 0; len_wr = 0;
    len_val = '0; stat_clr = '0; pkt_valid = 0; pkt_bytes = '0;
  endtask

  task automatic setup(input int len, input bit arm, input bit dir);
    @(negedge clk);
    len_wr = 1; len_val = LEN_W'(len); arm_wr = 1; arm_val = arm;
    dir_wr = 1; dir_val = dir; stat_clr = 3'b111;
    @(negedge clk);
    idle_all();
  endtask

  task automatic send(input int b, input logic [2:0] clr);
    @(negedge clk);
    pkt_valid = 1; pkt_bytes = CNT_W'(b); stat_clr = clr;
    @(negedge clk);
    pkt_valid = 0; stat_clr = '0;
    got_v = hs_valid; got_ack = hs_ack;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int lens[8] = '{0, 1, 5, 63, 64, 65, 128, 320};
    idle_all();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 armed", armed, 0);
    chk("R1 remain", remain_len, 0);
    chk("R1 flags", flg(), 0);
    chk("R1 hs_valid", hs_valid, 0);

    // R2 disarmed endpoint
    setup(100, 0, 0);
    send(10, 3'b000);
    chk("R2 ack disarmed", got_ack, 0);
    chk("R10 hs_valid", got_v, 1);
    chk("R2 remain disarmed", remain_len, 100);
    chk("R2 flags disarmed", flg(), 0);
    @(negedge clk);
    chk("R10 hs pulse ends", hs_valid, 0);
    // R2 wrong direction
    setup(100, 1, 1);
    send(10, 3'b000);
    chk("R2 ack dir", got_ack, 0);
    chk("R2 remain dir", remain_len, 100);
    chk("R2 armed dir", armed, 1);
    chk("R2 flags dir", flg(), 0);

    // R3 long transfer: 320 bytes programmed, 259 received
    setup(320, 1, 0);
    for (int k = 0; k < 4; k++) begin
      send(64, 3'b000);
      chk("R3 ack full", got_ack, 1);
      chk("R8 armed after full", armed, 1);
      chk("R8 no tc", irq_tc, 0);
      chk("R3 remain step", remain_len, 320 - 64 * (k + 1));
    end
    send(3, 3'b000);
    chk("R3 remain 61", remain_len, 61);
    chk("R5 disarmed short", armed, 0);
    chk("R5 flags short", flg(), 3'b101);
    send(3, 3'b000);
    chk("R2 nak after end", got_ack, 0);
    chk("R2 remain kept", remain_len, 61);

    // R9 partial clear, then set wins over clear
    @(negedge clk); stat_clr = 3'b001;
    @(negedge clk); stat_clr = 3'b000;
    chk("R9 clear pc only", flg(), 3'b100);
    setup(200, 1, 0);
    send(64, 3'b000);
    send(64, 3'b001);
    chk("R9 set wins", irq_pc, 1);

    // Sweep byte counts against lengths: R3 R4 R5 R6 R7 R8
    foreach (lens[li]) begin
      for (int b = 0; b <= MAX_PKT + 1; b++) begin
        int  L;
        bit  acc, tc, bcz;
        L   = lens[li];
        acc = (b <= MAX_PKT) && (b <= L);
        bcz = acc && (L - b == 0);
        tc  = acc && ((b < MAX_PKT) || bcz);
        setup(L, 1, 0);
        send(b, 3'b000);
        chk("R7 ack decision", got_ack, int'(acc));
        chk("R3 remain sweep", remain_len, acc ? L - b : L);
        chk("R4 R5 R6 flags", flg(), {tc, bcz, acc});
        chk("R5 R6 R8 armed", armed, int'(!tc));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule